// File: doc/BRIEF.md
# Two-Thread Allocation Arbiter

This block decides, once per clock, which of two hardware threads may place one micro-op into the back-end buffers that the threads share. A thread is a candidate when its micro-op queue holds work, its reservation-station share is not full, it still has room in its reorder-buffer share, and the current thread mode lets it run. When both threads are candidates, the grant alternates between them. When only one is a candidate, it takes every slot, so a stalled thread never costs the other one bandwidth.

The block keeps a reorder-buffer occupancy count for each thread. A count rises when that thread is granted and falls when the back end pulses that thread's release input. With both threads running, each thread may hold at most half of the entries. In a single-thread mode the running thread may fill the whole buffer, and the idle thread is never granted. The turn pointer advances only when the thread whose turn it was actually allocates, so a thread that stalls keeps its priority for the next cycle in which it is ready.

Top module: `smt_alloc_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `grant` is 00, `turn` is 0 and both occupancy counts are 0.
- R2: Thread i is granted only if `uq_nonempty[i]` is 1 and `rs_full[i]` is 0, its occupancy count is below its limit, and the mode allows thread i to run.
- R3: When both threads stay eligible, `grant` alternates between 01 (thread 0) and 10 (thread 1) on successive cycles, starting from the thread named by `turn`.
- R4: When the thread named by `turn` is not eligible and the other thread is eligible, the other thread is granted in that cycle.
- R5: `turn` toggles after a cycle in which the thread it names is granted, and otherwise keeps its value.
- R6: `grant` has at most one bit set in any cycle.
- R7: A thread's occupancy count rises by one after a cycle with a grant to it and no release, falls by one after a cycle with a release and no grant, and is unchanged when both or neither occur. A release while the count is 0 is ignored.
- R8: In mode 00 (both threads active), each thread stops being granted once its count reaches TOTAL_ENTRIES/2 (24 by default). The other thread is still served.
- R9: In mode 01 only thread 0 runs, and in mode 10 only thread 1 runs. The running thread may fill up to TOTAL_ENTRIES (48), and the other thread is never granted. If the mode returns to 00 while a count is above half, that thread is blocked until its count drops below half.
- R10: Mode 11 behaves exactly like mode 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Thread mode: 00 both active, 01 thread 0 only, 10 thread 1 only, 11 treated as 00 |
| uq_nonempty | input | 2 | Per-thread micro-op queue holds work (bit i is thread i) |
| rs_full | input | 2 | Per-thread reservation-station share is full |
| rel_req | input | 2 | Per-thread pulse that frees one reorder-buffer entry |
| grant | output | 2 | One-hot-or-zero allocation grant for this cycle |
| turn | output | 1 | Thread that has priority in the current cycle |
| occ_count | output | 2x6 | Per-thread reorder-buffer occupancy, index i is thread i |

## Verification
The assertions assume that the back end pulses `rel_req[i]` only for entries that thread i really holds. The counter also drops extra releases at zero, so an out-of-range pulse cannot break the occupancy bounds. They also assume that `mode` changes only between clock edges and stays stable within a cycle. The directed stimulus drives every input on the falling edge and reads the outputs just after it. Releases are issued only when a thread's count is known, except in the one deliberate case that checks a release at zero is ignored. Mode changes go through either a fresh reset or a state whose counts are already known. This keeps every expected grant and count computable from the requirements alone.

// File: rtl/alloc_arb_pkg.sv
// Package: shared types for the two-thread allocation arbiter.
// Assumes exactly two hardware threads; thread index 0 and 1 map to bit 0/1.
package alloc_arb_pkg;

    localparam int NUM_THREADS = 2;

    // Thread-mode encoding presented on the top-level mode input.
    typedef enum logic [1:0] {
        MODE_DUAL     = 2'b00,
        MODE_SOLO0    = 2'b01,
        MODE_SOLO1    = 2'b10,
        MODE_DUAL_ALT = 2'b11
    } thr_mode_e;

    // True when the given thread may run under the given mode.
    function automatic logic thread_enabled(thr_mode_e m, int unsigned tid);
        logic en;
        case (m)
            MODE_SOLO0: en = (tid == 0);
            MODE_SOLO1: en = (tid == 1);
            default:    en = 1'b1;
        endcase
        return en;
    endfunction

    // True when the mode shares the buffer between both threads.
    function automatic logic mode_is_shared(thr_mode_e m);
        return (m == MODE_DUAL) || (m == MODE_DUAL_ALT);
    endfunction

endpackage

// File: rtl/alloc_occ_counter.sv
// Module: alloc_occ_counter
// Tracks the reorder-buffer entries held by one thread.
// Adds one per allocation and removes one per release. A release at zero and
// an allocation at MAX_COUNT are dropped. The upstream limit logic is
// expected never to grant at MAX_COUNT.
module alloc_occ_counter #(
    parameter int CNT_W     = 6,
    parameter int MAX_COUNT = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] MAX_VAL = CNT_W'(MAX_COUNT);

    logic do_inc;
    logic do_dec;

    // Qualify the raw requests against the counter bounds.
    always_comb begin
        do_inc = inc && (count != MAX_VAL);
        do_dec = dec && (count != '0);
    end

    // Occupancy register; simultaneous add and remove cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (do_inc && !do_dec) begin
            count <= count + 1'b1;
        end else if (do_dec && !do_inc) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/alloc_limit_calc.sv
// Module: alloc_limit_calc
// Works out, for each thread, whether the mode lets it run and whether its
// occupancy is still below its share of the buffer. The share is half of the
// total when both threads run, and the whole buffer when only one runs.
// Purely combinational.
module alloc_limit_calc
    import alloc_arb_pkg::*;
#(
    parameter int TOTAL_ENTRIES = 48,
    parameter int CNT_W         = 6
) (
    input  thr_mode_e                              mode,
    input  logic [NUM_THREADS-1:0][CNT_W-1:0]      occ,
    output logic [NUM_THREADS-1:0]                 enabled,
    output logic [NUM_THREADS-1:0]                 has_room
);

    localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(TOTAL_ENTRIES);
    localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(TOTAL_ENTRIES / 2);

    logic [CNT_W-1:0] limit;

    // Pick the per-thread capacity for the current mode.
    always_comb begin
        limit = mode_is_shared(mode) ? HALF_LIM : FULL_LIM;
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        // Mode enable and capacity check for thread t.
        always_comb begin
            enabled[t]  = thread_enabled(mode, t);
            has_room[t] = (occ[t] < limit);
        end
    end

endmodule

// File: rtl/alloc_pingpong_pick.sv
// Module: alloc_pingpong_pick
// Grants one of two eligible requesters, using a turn pointer that favours
// the thread whose turn it is. An eligible thread also wins when the other
// thread cannot be picked. The pointer toggles only when the favoured thread
// was granted. Assumes elig is settled before the clock edge.
module alloc_pingpong_pick (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] elig,
    output logic [1:0] grant,
    output logic       turn
);

    logic turn_won;

    // Turn-aware selection: priority to the turn holder, fallback to the other.
    always_comb begin
        grant[0] = elig[0] && (!turn || !elig[1]);
        grant[1] = elig[1] && ( turn || !elig[0]);
        turn_won = turn ? grant[1] : grant[0];
    end

    // Turn pointer: advances only when the favoured thread allocated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn <= 1'b0;
        end else if (turn_won) begin
            turn <= ~turn;
        end
    end

endmodule

// File: rtl/smt_alloc_arbiter.sv
// Module: smt_alloc_arbiter
// Top level of the two-thread allocation arbiter. It combines the per-thread
// ready flags with the occupancy limits and grants at most one thread per
// cycle. It also keeps the per-thread reorder-buffer occupancy counts.
// Assumes rel_req[i] is pulsed once per entry that thread i retires or frees.
module smt_alloc_arbiter
    import alloc_arb_pkg::*;
#(
    parameter int TOTAL_ENTRIES = 48,
    parameter int CNT_W         = $clog2(TOTAL_ENTRIES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode,
    input  logic [1:0]            uq_nonempty,
    input  logic [1:0]            rs_full,
    input  logic [1:0]            rel_req,
    output logic [1:0]            grant,
    output logic                  turn,
    output logic [1:0][CNT_W-1:0] occ_count
);

    thr_mode_e  mode_q;
    logic [1:0] enabled;
    logic [1:0] has_room;
    logic [1:0] elig;

    // Interpret the raw mode bits as the mode type.
    always_comb begin
        mode_q = thr_mode_e'(mode);
    end

    alloc_limit_calc #(
        .TOTAL_ENTRIES (TOTAL_ENTRIES),
        .CNT_W         (CNT_W)
    ) u_limit (
        .mode     (mode_q),
        .occ      (occ_count),
        .enabled  (enabled),
        .has_room (has_room)
    );

    // Per-thread eligibility: work queued, station free, room left, mode allows.
    always_comb begin
        elig = uq_nonempty & ~rs_full & has_room & enabled;
    end

    alloc_pingpong_pick u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .grant (grant),
        .turn  (turn)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_occ
        alloc_occ_counter #(
            .CNT_W     (CNT_W),
            .MAX_COUNT (TOTAL_ENTRIES)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (grant[t]),
            .dec   (rel_req[t]),
            .count (occ_count[t])
        );
    end

endmodule

// File: rtl/alloc_arb_checker.sv
// Module: alloc_arb_checker
// Property checks for smt_alloc_arbiter, attached through bind below.
// Assumes rel_req only frees entries a thread holds and mode is stable within
// a cycle.
module alloc_arb_checker #(
    parameter int TOTAL_ENTRIES = 48,
    parameter int CNT_W         = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            mode,
    input logic [1:0]            uq_nonempty,
    input logic [1:0]            rs_full,
    input logic [1:0]            rel_req,
    input logic [1:0]            grant,
    input logic                  turn,
    input logic [1:0][CNT_W-1:0] occ_count
);

    localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(TOTAL_ENTRIES / 2);
    localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(TOTAL_ENTRIES);

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_ready0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |-> (uq_nonempty[0] && !rs_full[0]));

    p_ready1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant[1] |-> (uq_nonempty[1] && !rs_full[1]));

    p_solo0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> !grant[1]);

    p_solo1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> !grant[0]);

    p_turn_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grant[turn] |=> (turn != $past(turn)));

    p_turn_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !grant[turn] |=> (turn == $past(turn)));

    p_cnt_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && !rel_req[0]) |=> (occ_count[0] == $past(occ_count[0]) + 1'b1));

    p_cnt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant[1] && !rel_req[1]) |=> $stable(occ_count[1]));

    p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_count[0] <= FULL_LIM) && (occ_count[1] <= FULL_LIM));

    p_shared_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b00) && occ_count[0] >= HALF_LIM) |-> !grant[0]);

    p_work_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uq_nonempty[0] && !rs_full[0] && mode != 2'b10 && occ_count[0] < HALF_LIM)
            |-> (grant != 2'b00));

endmodule

bind smt_alloc_arbiter alloc_arb_checker #(
    .TOTAL_ENTRIES (TOTAL_ENTRIES),
    .CNT_W         (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .uq_nonempty (uq_nonempty),
    .rs_full     (rs_full),
    .rel_req     (rel_req),
    .grant       (grant),
    .turn        (turn),
    .occ_count   (occ_count)
);

// File: tb/smt_alloc_arbiter_bench.sv
`timescale 1ns/1ps
// Directed bench for smt_alloc_arbiter: one task per scenario.
// Inputs change on the falling edge, and outputs are read 1 ns later.
module smt_alloc_arbiter_bench;

    localparam int TOTAL = 48;
    localparam int CW    = 6;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [1:0]         mode;
    logic [1:0]         uq_nonempty;
    logic [1:0]         rs_full;
    logic [1:0]         rel_req;
    logic [1:0]         grant;
    logic               turn;
    logic [1:0][CW-1:0] occ_count;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    smt_alloc_arbiter #(.TOTAL_ENTRIES(TOTAL)) u_smt_alloc_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .uq_nonempty (uq_nonempty),
        .rs_full     (rs_full),
        .rel_req     (rel_req),
        .grant       (grant),
        .turn        (turn),
        .occ_count   (occ_count)
    );

    // Compare one value and log a failure line.
    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive inputs at the falling edge and let combinational outputs settle.
    task automatic drive(logic [1:0] m, logic [1:0] uq, logic [1:0] rs, logic [1:0] rl);
        @(negedge clk);
        mode = m; uq_nonempty = uq; rs_full = rs; rel_req = rl;
        #1;
    endtask

    // Apply the synchronous reset for three edges.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mode = 2'b00; uq_nonempty = 2'b00; rs_full = 2'b00; rel_req = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: reset values on all outputs.
    task automatic t_reset();
        do_reset();
        drive(2'b00, 2'b00, 2'b00, 2'b00);
        check("R1 grant", grant, 0);
        check("R1 turn", turn, 0);
        check("R1 occ0", occ_count[0], 0);
        check("R1 occ1", occ_count[1], 0);
    endtask

    // R3/R5/R6/R7: both ready, so grants alternate and the turn follows.
    task automatic t_alternate(logic [1:0] m, string tag);
        do_reset();
        for (int i = 0; i < 4; i++) begin
            drive(m, 2'b11, 2'b00, 2'b00);
            check({tag, " alternate grant"}, grant, (i % 2 == 0) ? 1 : 2);
            check("R5 turn", turn, i % 2);
        end
        drive(m, 2'b00, 2'b00, 2'b00);
        check("R7 occ0 after two grants", occ_count[0], 2);
        check("R7 occ1 after two grants", occ_count[1], 2);
        check("R5 turn back to 0", turn, 0);
    endtask

    // R4/R5/R2: the turn holder is blocked, the other wins, and the turn holds.
    task automatic t_skip();
        do_reset();
        drive(2'b00, 2'b10, 2'b00, 2'b00);
        check("R4 other thread granted", grant, 2);
        drive(2'b00, 2'b10, 2'b00, 2'b00);
        check("R5 turn held", turn, 0);
        check("R4 other thread again", grant, 2);
        drive(2'b00, 2'b11, 2'b01, 2'b00);
        check("R2 rs_full blocks thread 0", grant, 2);
        drive(2'b00, 2'b11, 2'b00, 2'b00);
        check("R4 turn holder regains priority", grant, 1);
    endtask

    // R7: release, grant with release, release at zero.
    task automatic t_release();
        do_reset();
        repeat (3) drive(2'b00, 2'b01, 2'b00, 2'b00);
        drive(2'b00, 2'b00, 2'b00, 2'b01);
        check("R7 occ0 after 3 grants", occ_count[0], 3);
        drive(2'b00, 2'b01, 2'b00, 2'b01);
        check("R7 occ0 after release", occ_count[0], 2);
        drive(2'b00, 2'b00, 2'b00, 2'b10);
        check("R7 grant+release no change", occ_count[0], 2);
        drive(2'b00, 2'b00, 2'b00, 2'b00);
        check("R7 release at zero ignored", occ_count[1], 0);
    endtask

    // R8: in shared mode a thread stops at half capacity; the other is still served.
    task automatic t_fill_shared();
        int got = 0;
        do_reset();
        for (int i = 0; i < 40; i++) begin
            drive(2'b00, 2'b01, 2'b00, 2'b00);
            if (grant[0]) got++;
        end
        check("R8 grants before cap", got, TOTAL / 2);
        check("R8 occ0 at cap", occ_count[0], TOTAL / 2);
        check("R8 capped thread not granted", grant, 0);
        drive(2'b00, 2'b11, 2'b00, 2'b00);
        check("R8 other thread still served", grant, 2);
    endtask

    // R9: solo modes recombine capacity; the idle thread is never granted.
    task automatic t_solo();
        int got0 = 0;
        int got1 = 0;
        do_reset();
        for (int i = 0; i < 60; i++) begin
            drive(2'b01, 2'b11, 2'b00, 2'b00);
            if (grant[0]) got0++;
            if (grant[1]) got1++;
        end
        check("R9 solo0 fills whole buffer", got0, TOTAL);
        check("R9 idle thread never granted", got1, 0);
        check("R9 occ0 full", occ_count[0], TOTAL);
        drive(2'b00, 2'b11, 2'b00, 2'b00);
        check("R9 back to shared, over-half thread blocked", grant, 2);
        do_reset();
        for (int i = 0; i < 4; i++) begin
            drive(2'b10, 2'b11, 2'b00, 2'b00);
            check("R9 solo1 grants thread 1 only", grant, 2);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'b00; uq_nonempty = 2'b00; rs_full = 2'b00; rel_req = 2'b00;
        t_reset();
        t_alternate(2'b00, "R3");
        t_alternate(2'b11, "R10");
        t_skip();
        t_release();
        t_fill_shared();
        t_solo();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule